// File: doc/BRIEF.md
# Video Capture Frame Interrupt Generator

This block follows the line timing of a video capture path and raises two kinds of single-cycle interrupt pulse toward the processor. A start event marks a fixed point near the top of every frame or field. Its position depends on the scan mode. An end event marks the moment the memory write path reports that the last burst of the frame has been stored. The two events are independent, so each frame normally produces two interrupts.

Every event is also latched into a sticky status word, which software clears by writing ones. A per-source mask gates the interrupt pins but never the status bits. The first start event after capture is switched on carries no completed frame before it. That event sets a separate first-frame status bit so software can discard it. In interlaced modes the field identity present at each start event is captured in status.

Top module: `frame_irq_gen`

## Requirements
- R1: After reset, irq_start and irq_end are 0 and all four status bits are 0.
- R2: With mode = 2'b01 (interlaced, embedded-sync), a start event occurs when line_start is high with line_num = 11 and the previous line_start carried line_num = 10. Line 11 reached from any other line gives no event.
- R3: With mode = 2'b00 (progressive, embedded-sync), a start event occurs when line_start is high with line_num = 5 and the previous line_start carried line_num = 4.
- R4: With mode bit 1 set (raw sensor capture), a start event occurs on the first line_start at which vvalid is high after a line_start at which vvalid was low. Later valid lines give no event.
- R5: An end event occurs in every cycle where xfer_done is high, whatever the line position.
- R6: An event shows on its interrupt output one clock after the inputs that cause it, for exactly one cycle.
- R7: Status bits 0 (start), 1 (end) and 2 (first frame) stay set until a clear cycle with clr_we high writes a 1 to that bit of clr_bits. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R8: irq_start is gated by mask bit 0 and irq_end by mask bit 1. The status bit is recorded whatever the mask.
- R9: Status bit 2 is set together with the first start event after a rising edge of cap_en. It is not set by later start events. The armed state is kept while cap_en is low, and every rising edge of cap_en re-arms it.
- R10: On each start event, status bit 3 takes field_in when mode bit 0 is set and takes 0 otherwise. Between start events, status bit 3 holds its value.
- R11: A start event and an end event in the same cycle set both status bits and both enabled outputs.
- R12: While cap_en is low, no start or end event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| mode | input | 2 | Bit 1: raw sensor capture; bit 0: interlaced scan |
| line_start | input | 1 | Strobe at the first cycle of each line |
| line_num | input | LINE_W | Number of the line that is starting, valid with line_start |
| field_in | input | 1 | Current field identity from the timing logic |
| vvalid | input | 1 | Vertical valid pixel region indication (raw mode) |
| xfer_done | input | 1 | Last burst of the frame written to memory |
| irq_mask | input | 2 | Bit 0 enables irq_start, bit 1 enables irq_end |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 3 | Write-one-to-clear data for status bits 2..0 |
| irq_start | output | 1 | Start-of-frame interrupt pulse |
| irq_end | output | 1 | End-of-frame interrupt pulse |
| status | output | 4 | Bit 0 start, bit 1 end, bit 2 first frame, bit 3 field id |

## Verification
The assertions assume that mask and clear inputs are ordinary synchronous signals. They also assume that line_num is meaningful only in the cycles where line_start is high. Nothing is assumed about how often xfer_done fires compared with the line strobes. The stimulus changes every input only between clock edges. It gives each line its own line_start cycle and walks line numbers through the mode boundaries both in order and with a jump. It also places xfer_done and a status clear deliberately on top of start events, so the coincidence cases are exercised.

// File: rtl/fi_pkg.sv
// Shared definitions for the frame interrupt generator.
// Assumes: mode bit 1 selects raw capture, bit 0 selects interlaced scan.
package fi_pkg;
    typedef enum logic [1:0] {
        FI_PROG_BT = 2'b00,
        FI_INTL_BT = 2'b01,
        FI_RAW_P   = 2'b10,
        FI_RAW_I   = 2'b11
    } scan_mode_e;

    localparam int ST_START = 0;
    localparam int ST_END   = 1;
    localparam int ST_FIRST = 2;
    localparam int ST_FIELD = 3;
    localparam int ST_W     = 4;
    localparam int CLR_W    = 3;
endpackage

// File: rtl/fi_start_detect.sv
// Start-of-frame detector: decides, in the cycle of a line_start strobe,
// whether that line is the start point for the selected scan mode.
// Embedded-sync modes look for a fixed line-number transition; raw mode
// looks for the first line inside the vertical valid region.
// Assumes: line_num and vvalid are meaningful only while line_start is high.
module fi_start_detect
    import fi_pkg::*;
#(
    parameter int LINE_W   = 11,
    parameter int IL_START = 11,
    parameter int PR_START = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              vvalid,
    input  scan_mode_e        mode,
    output logic              start_hit
);
    localparam logic [LINE_W-1:0] IL_LINE = LINE_W'(IL_START);
    localparam logic [LINE_W-1:0] IL_PREV = LINE_W'(IL_START - 1);
    localparam logic [LINE_W-1:0] PR_LINE = LINE_W'(PR_START);
    localparam logic [LINE_W-1:0] PR_PREV = LINE_W'(PR_START - 1);

    logic [LINE_W-1:0] prev_line;
    logic              prev_vvalid;
    logic              bt_hit;
    logic              raw_hit;

    // Remember the line number and valid flag carried by the last line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_line   <= '0;
            prev_vvalid <= 1'b0;
        end else if (line_start) begin
            prev_line   <= line_num;
            prev_vvalid <= vvalid;
        end
    end

    // Embedded-sync match: selected boundary line reached from its predecessor.
    always_comb begin
        if (mode[0]) bt_hit = (line_num == IL_LINE) && (prev_line == IL_PREV);
        else         bt_hit = (line_num == PR_LINE) && (prev_line == PR_PREV);
    end

    // Raw match: leading line of the vertical valid region.
    always_comb raw_hit = vvalid && !prev_vvalid;

    // Final selection by capture type, only on a line strobe.
    always_comb start_hit = line_start && (mode[1] ? raw_hit : bt_hit);
endmodule

// File: rtl/fi_first_arm.sv
// First-frame arming: a rising edge of capture enable arms the flag, and the
// next start event consumes it. The armed state is held while capture is off.
// Assumes: start_ev is already qualified by capture enable.
module fi_first_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic start_ev,
    output logic first_hit
);
    logic cap_en_q;
    logic armed;

    // Track capture enable and the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en_q <= 1'b0;
            armed    <= 1'b0;
        end else begin
            cap_en_q <= cap_en;
            if (cap_en && !cap_en_q) armed <= 1'b1;
            else if (start_ev)       armed <= 1'b0;
        end
    end

    // The start event that finds the flag armed is the one to ignore.
    always_comb first_hit = start_ev && armed;
endmodule

// File: rtl/fi_sticky.sv
// Bank of sticky status bits with write-one-to-clear; a set wins over a clear
// in the same cycle so no event is lost.
// Assumes: set and clr are single-cycle qualified strobes.
module fi_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit: set has priority, otherwise clear, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_irq_gen.sv
// Frame interrupt generator top: qualifies start and end events with capture
// enable, drives masked single-cycle interrupt pulses, and keeps the sticky
// status word (start, end, first frame, field id).
// Assumes: all inputs are synchronous to clk.
module frame_irq_gen
    import fi_pkg::*;
#(
    parameter int LINE_W   = 11,
    parameter int IL_START = 11,
    parameter int PR_START = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        mode,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_in,
    input  logic              vvalid,
    input  logic              xfer_done,
    input  logic [1:0]        irq_mask,
    input  logic              clr_we,
    input  logic [CLR_W-1:0]  clr_bits,
    output logic              irq_start,
    output logic              irq_end,
    output logic [ST_W-1:0]   status
);
    scan_mode_e       mode_e;
    logic             start_hit;
    logic             start_ev;
    logic             end_ev;
    logic             first_hit;
    logic [CLR_W-1:0] sticky_set;
    logic [CLR_W-1:0] sticky_clr;
    logic [CLR_W-1:0] sticky_q;
    logic             field_q;

    // Cast the raw mode pins to the shared enum.
    always_comb mode_e = scan_mode_e'(mode);

    fi_start_detect #(
        .LINE_W  (LINE_W),
        .IL_START(IL_START),
        .PR_START(PR_START)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .line_num  (line_num),
        .vvalid    (vvalid),
        .mode      (mode_e),
        .start_hit (start_hit)
    );

    // Events exist only while capture is enabled.
    always_comb begin
        start_ev = start_hit && cap_en;
        end_ev   = xfer_done && cap_en;
    end

    fi_first_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .start_ev (start_ev),
        .first_hit(first_hit)
    );

    // Map events and software clears onto the sticky bank.
    always_comb begin
        sticky_set           = '0;
        sticky_set[ST_START] = start_ev;
        sticky_set[ST_END]   = end_ev;
        sticky_set[ST_FIRST] = first_hit;
        sticky_clr           = clr_we ? clr_bits : '0;
    end

    fi_sticky #(.N(CLR_W)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (sticky_set),
        .clr  (sticky_clr),
        .q    (sticky_q)
    );

    // Capture the field identity at each start event (interlaced only).
    always_ff @(posedge clk) begin
        if (!rst_n)        field_q <= 1'b0;
        else if (start_ev) field_q <= mode_e[0] ? field_in : 1'b0;
    end

    // Masked single-cycle interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_start <= 1'b0;
            irq_end   <= 1'b0;
        end else begin
            irq_start <= start_ev && irq_mask[0];
            irq_end   <= end_ev && irq_mask[1];
        end
    end

    // Assemble the status word.
    always_comb status = {field_q, sticky_q};
endmodule

// File: rtl/frame_irq_gen_chk.sv
// Checker for the frame interrupt generator, bound to every instance.
module frame_irq_gen_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic [1:0]        irq_mask,
    input logic              clr_we,
    input logic [2:0]        clr_bits,
    input logic              irq_start,
    input logic              irq_end,
    input logic [3:0]        status
);
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |=> !irq_start);
    // R6
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |=> !irq_end);
    // R8
    start_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask[0] |=> !irq_start);
    // R8
    end_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask[1] |=> !irq_end);
    // R7
    start_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> status[0]);
    // R7
    end_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> status[1]);
    // R7
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(clr_we && clr_bits[0])) |=> status[0]);
    // R7
    end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(clr_we && clr_bits[1])) |=> status[1]);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (!irq_start && !irq_end));
    // R9
    first_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> status[0]);
endmodule

bind frame_irq_gen frame_irq_gen_chk #(.LINE_W(LINE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .irq_mask (irq_mask),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .irq_start(irq_start),
    .irq_end  (irq_end),
    .status   (status)
);

// File: tb/frame_irq_gen_test.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module frame_irq_gen_test;
    localparam int LW = 11;

    typedef struct {
        logic       irq_s;
        logic       irq_e;
        logic [3:0] sts;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_en = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          line_start = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic          field_in = 1'b0;
    logic          vvalid = 1'b0;
    logic          xfer_done = 1'b0;
    logic [1:0]    irq_mask = 2'b11;
    logic          clr_we = 1'b0;
    logic [2:0]    clr_bits = '0;
    logic          irq_start;
    logic          irq_end;
    logic [3:0]    status;

    int n_checks = 0;
    int n_fails  = 0;
    exp_t q[$];

    // Requested settings applied by the next step.
    logic       n_cap = 1'b0;
    logic [1:0] n_mode = 2'b00;
    logic [1:0] n_mask = 2'b11;

    // Reference state.
    logic [LW-1:0] m_prev = '0;
    logic          m_vv = 1'b0;
    logic          m_armed = 1'b0;
    logic          m_cap = 1'b0;
    logic [3:0]    m_sts = '0;

    always #2 clk = ~clk;

    frame_irq_gen #(.LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode(mode),
        .line_start(line_start), .line_num(line_num), .field_in(field_in),
        .vvalid(vvalid), .xfer_done(xfer_done), .irq_mask(irq_mask),
        .clr_we(clr_we), .clr_bits(clr_bits),
        .irq_start(irq_start), .irq_end(irq_end), .status(status)
    );

    task automatic step(input logic ls, input int ln, input logic fld,
                        input logic vv, input logic xd, input logic [2:0] clr,
                        input string tag);
        logic ev_s, ev_e, rise;
        int   s_line;
        exp_t e;
        @(negedge clk);
        cap_en = n_cap; mode = n_mode; irq_mask = n_mask;
        line_start = ls; line_num = LW'(ln); field_in = fld; vvalid = vv;
        xfer_done = xd; clr_we = (clr != 0); clr_bits = clr;
        s_line = n_mode[0] ? 11 : 5;
        if (n_mode[1]) ev_s = n_cap && ls && vv && !m_vv;
        else ev_s = n_cap && ls && (ln == s_line) && (m_prev == LW'(s_line - 1));
        ev_e = n_cap && xd;
        rise = n_cap && !m_cap;
        m_sts[0] = ev_s | (m_sts[0] & ~clr[0]);
        m_sts[1] = ev_e | (m_sts[1] & ~clr[1]);
        m_sts[2] = (ev_s & m_armed) | (m_sts[2] & ~clr[2]);
        if (ev_s) m_sts[3] = n_mode[0] ? fld : 1'b0;
        if (ls) begin m_prev = LW'(ln); m_vv = vv; end
        if (rise) m_armed = 1'b1; else if (ev_s) m_armed = 1'b0;
        m_cap = n_cap;
        e.irq_s = ev_s & n_mask[0];
        e.irq_e = ev_e & n_mask[1];
        e.sts = m_sts;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, m_vv, 0, 3'b000, tag);
    endtask

    // Monitor: compare one queued expectation per clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (irq_start !== e.irq_s || irq_end !== e.irq_e || status !== e.sts) begin
                    n_fails++;
                    $display("FAIL %s: got irq_start=%b irq_end=%b status=%b, expected %b %b %b",
                             e.tag, irq_start, irq_end, status, e.irq_s, e.irq_e, e.sts);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        n_checks++;
        if (irq_start !== 1'b0 || irq_end !== 1'b0 || status !== 4'b0) begin
            n_fails++;
            $display("FAIL R1: got %b %b %b, expected 0 0 0000", irq_start, irq_end, status);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 progressive boundary, R9 first flag, R6 single pulse
        n_mode = 2'b00; n_cap = 1'b1; n_mask = 2'b11;
        idle(2, "R9 arm");
        for (int l = 1; l <= 7; l++) begin
            step(1, l, 0, 0, 0, 3'b000, "R3 progressive line");
            idle(1, "R6 pulse width");
        end
        // R7 clear all
        step(0, 0, 0, 0, 0, 3'b111, "R7 w1c");
        idle(1, "R7 cleared");

        // R5 end event, R8 masked end still recorded
        n_mask = 2'b01;
        step(0, 0, 0, 0, 1, 3'b000, "R8 masked end");
        n_mask = 2'b11;
        step(1, 3, 0, 0, 1, 3'b000, "R5 end mid-frame");
        idle(2, "R7 hold");
        step(0, 0, 0, 0, 0, 3'b011, "R7 w1c");

        // R2 interlaced boundary, R10 field capture
        n_mode = 2'b01;
        for (int l = 8; l <= 12; l++) step(1, l, 1, 0, 0, 3'b000, "R2 interlaced line");
        step(1, 3, 0, 0, 0, 3'b000, "R2 jump");
        step(1, 11, 0, 0, 0, 3'b000, "R2 line 11 without 10");
        // R11 coincident start and end, with a clear of both that loses
        step(1, 10, 0, 0, 0, 3'b000, "R11 prep");
        step(1, 11, 0, 0, 1, 3'b011, "R11 coincident events");
        idle(1, "R11 recorded");
        // R8 start masked but recorded, R10 field 1
        n_mask = 2'b10;
        step(0, 0, 0, 0, 0, 3'b001, "R7 w1c");
        step(1, 10, 1, 0, 0, 3'b000, "R8 prep");
        step(1, 11, 1, 0, 0, 3'b000, "R8 masked start R10");
        n_mask = 2'b11;

        // R12 capture off: no events, armed state held
        n_cap = 1'b0;
        step(0, 0, 0, 0, 0, 3'b111, "R12 clear");
        step(1, 10, 0, 0, 0, 3'b000, "R12 prep");
        step(1, 11, 0, 0, 1, 3'b000, "R12 suppressed");
        idle(1, "R12 quiet");

        // R4 raw capture after re-arm (R9)
        n_mode = 2'b10; n_cap = 1'b1;
        idle(1, "R9 rearm");
        step(1, 1, 0, 0, 0, 3'b000, "R4 blank line");
        step(1, 2, 0, 0, 0, 3'b000, "R4 blank line");
        step(1, 3, 0, 1, 0, 3'b000, "R4 first valid R9");
        step(1, 4, 0, 1, 0, 3'b000, "R4 second valid");
        step(1, 5, 0, 0, 0, 3'b000, "R4 after region");
        step(0, 0, 0, 0, 0, 3'b111, "R7 w1c");
        step(1, 6, 1, 1, 0, 3'b000, "R4 next region no first");
        idle(2, "R4 settle");

        repeat (2) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule